// File: doc/BRIEF.md
# Byte to word width adapter

This block joins an 8-bit internal byte stream to an external parallel data port. The port is either one lane wide, carrying a byte per clock, or two lanes wide, carrying a 16-bit word. In receive, bytes from the internal side are delivered on the port. In word mode they are first paired into words, and a high-half flag tells whether the upper lane holds data. In transmit, words taken from the port are broken into bytes for the internal serializer, low byte first. A high-half flag that arrives with the word drops a missing upper byte.

The layout is chosen by two configuration inputs. These are captured only while reset is held, so the last value present before reset is released stays in force until the next reset. The three layouts are bidirectional byte, split byte and word. In the split byte layout the lower lane always carries receive data and the upper lane always carries transmit data. The high-half flag is shared: it points out of the block while transmit is idle and into it while transmit is active. The block gives out registered output enables for each lane and for the flag, and leaves the pad buffers to the surrounding logic.

Top module: `byte_word_adapter`

## Requirements
- R1: The layout is loaded from `cfg_wide_i`/`cfg_split_i` on every clock edge with `rst_n` low, and is held after release whatever those inputs do. `cfg_wide_i`=1 selects word. Otherwise `cfg_split_i`=1 selects split byte. Both low selects bidirectional byte.
- R2: While in reset, `port_oe_o`=00, `port_hbv_oe_o`=0, `port_rx_vld_o`=0, `port_hbv_o`=0 and `tx_byte_vld_o`=0, with `port_tx_rdy_o`=1.
- R3: In both byte layouts, a byte accepted on the internal receive side appears on `port_dout_o[7:0]` one cycle later, with `port_rx_vld_o`=1 for that one cycle and `port_hbv_o`=0.
- R4: In word layout, the first byte of a pair gives no output. The second byte produces, one cycle later, `port_dout_o`={second, first} with `port_rx_vld_o`=1 and `port_hbv_o`=1. Idle cycles between bytes give no output.
- R5: In word layout, a byte that carries `rx_byte_last_i` and opens a pair is sent alone, one cycle later, on `port_dout_o[7:0]` with `port_rx_vld_o`=1 and `port_hbv_o`=0. The next byte then opens a new pair.
- R6: In word layout, an accepted word gives its low byte (`port_din_i[7:0]`) first and its high byte second. The high byte is given only if `port_hbv_i` was 1 at acceptance. A byte offered while `tx_byte_rdy_i`=0 stays unchanged.
- R7: A word is accepted on an edge where `port_tx_vld_i`=1 and `port_tx_rdy_o`=1. `port_tx_rdy_o` is then 0 until the edge at which the last valid byte is consumed.
- R8: In the byte layouts, each accepted word yields exactly one byte: `port_din_i[7:0]` in bidirectional byte, `port_din_i[15:8]` in split byte.
- R9: `port_oe_o` is a register of `port_tx_vld_i`. In word layout both lanes are driven only when transmit was idle. In bidirectional byte, only lane 0 is driven, and only when transmit was idle. In split byte, lane 0 is always driven and lane 1 never is.
- R10: `port_hbv_oe_o` is 1 only in word layout with `port_tx_vld_i` low on the previous edge. `port_hbv_i` is used only at word acceptance in word layout.
- R11: In split byte, a receive byte and a transmit word handled on the same edge are both processed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide_i | input | 1 | Word layout select, captured in reset |
| cfg_split_i | input | 1 | Split byte layout select, captured in reset |
| rx_byte_i | input | LANE_W | Received byte from the internal side |
| rx_byte_vld_i | input | 1 | Received byte present |
| rx_byte_last_i | input | 1 | Received byte ends the packet |
| tx_byte_o | output | LANE_W | Byte offered to the serializer |
| tx_byte_vld_o | output | 1 | Transmit byte offered |
| tx_byte_rdy_i | input | 1 | Serializer takes the byte |
| port_din_i | input | 2*LANE_W | Data lanes as seen from the pads |
| port_dout_o | output | 2*LANE_W | Data lanes driven toward the pads |
| port_oe_o | output | 2 | Per-lane output enable |
| port_rx_vld_o | output | 1 | Low receive byte valid |
| port_tx_vld_i | input | 1 | Transmit word offered by the port side |
| port_tx_rdy_o | output | 1 | Block ready to take a transmit word |
| port_hbv_i | input | 1 | High-half flag, inbound during transmit |
| port_hbv_o | output | 1 | High-half flag, outbound during receive |
| port_hbv_oe_o | output | 1 | Output enable of the high-half flag |

## Verification
Two events can fall on the same edge in word layout: the receive word that completes a pair, and acceptance of a transmit word. The bench sends the second receive byte on the same edge that `port_tx_vld_i` is raised. It then checks that the finished word and both valid flags are present, that both lanes and the flag have turned inward, and that the low transmit byte is offered. In split byte, a receive byte and a transmit word share one edge, and the bench checks the lower-lane output and the upper-lane byte taken from that edge.

// File: rtl/bwa_pkg.sv
// Shared types and helpers for the byte/word width adapter.
// Assumes two lanes of equal width; lane 0 is the low half.
package bwa_pkg;

    typedef enum logic [1:0] {
        LINK_BYTE_BIDIR = 2'd0,
        LINK_BYTE_SPLIT = 2'd1,
        LINK_WORD       = 2'd2
    } link_mode_e;

    // Map the two configuration pins to a layout; word wins over split.
    function automatic link_mode_e pick_mode(input logic wide, input logic split);
        if (wide)
            return LINK_WORD;
        else if (split)
            return LINK_BYTE_SPLIT;
        return LINK_BYTE_BIDIR;
    endfunction

    // Whether a lane drives its pads, given layout and transmit activity.
    function automatic logic lane_drives(input link_mode_e m, input int unsigned lane,
                                         input logic tx_on);
        case (m)
            LINK_WORD:       return !tx_on;
            LINK_BYTE_SPLIT: return (lane == 0);
            default:         return (lane == 0) && !tx_on;
        endcase
    endfunction

endpackage

// File: rtl/bwa_mode_latch.sv
// Captures the port layout while reset is asserted and freezes it after.
// Assumes the configuration pins are stable during the final reset cycle.
module bwa_mode_latch
    import bwa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wide_i,
    input  logic       split_i,
    output link_mode_e mode_o
);

    link_mode_e mode_q;

    // Load layout during reset; hold it once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= pick_mode(wide_i, split_i);
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/bwa_rx_pack.sv
// Receive packer: passes bytes straight through in byte layouts, pairs
// them into words in word layout, and flushes a lone byte at packet end.
// Assumes at most one byte per cycle from the internal side.
module bwa_rx_pack
    import bwa_pkg::*;
#(
    parameter  int LANE_W = 8,
    localparam int BUS_W  = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  link_mode_e        mode_i,
    input  logic [LANE_W-1:0] byte_i,
    input  logic              byte_vld_i,
    input  logic              byte_last_i,
    output logic [BUS_W-1:0]  word_o,
    output logic              lo_vld_o,
    output logic              hi_vld_o
);

    logic              half_q;
    logic [LANE_W-1:0] lo_hold_q;
    logic [BUS_W-1:0]  word_q;
    logic              lo_vld_q;
    logic              hi_vld_q;

    // Pair or pass bytes and register the port-side word and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q    <= 1'b0;
            lo_hold_q <= '0;
            word_q    <= '0;
            lo_vld_q  <= 1'b0;
            hi_vld_q  <= 1'b0;
        end else begin
            lo_vld_q <= 1'b0;
            hi_vld_q <= 1'b0;
            if (byte_vld_i) begin
                if (mode_i != LINK_WORD) begin
                    word_q   <= {{LANE_W{1'b0}}, byte_i};
                    lo_vld_q <= 1'b1;
                end else if (!half_q) begin
                    if (byte_last_i) begin
                        word_q   <= {{LANE_W{1'b0}}, byte_i};
                        lo_vld_q <= 1'b1;
                    end else begin
                        lo_hold_q <= byte_i;
                        half_q    <= 1'b1;
                    end
                end else begin
                    word_q   <= {byte_i, lo_hold_q};
                    lo_vld_q <= 1'b1;
                    hi_vld_q <= 1'b1;
                    half_q   <= 1'b0;
                end
            end
        end
    end

    assign word_o   = word_q;
    assign lo_vld_o = lo_vld_q;
    assign hi_vld_o = hi_vld_q;

endmodule

// File: rtl/bwa_tx_unpack.sv
// Transmit unpacker: takes one port word into a holding register and
// offers its bytes low first; releases ready only after the last byte.
// Assumes the serializer handshakes with valid/ready on each byte.
module bwa_tx_unpack
    import bwa_pkg::*;
#(
    parameter  int LANE_W = 8,
    localparam int BUS_W  = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  link_mode_e        mode_i,
    input  logic              port_vld_i,
    input  logic [BUS_W-1:0]  port_data_i,
    input  logic              hi_vld_i,
    output logic              port_rdy_o,
    output logic [LANE_W-1:0] byte_o,
    output logic              byte_vld_o,
    input  logic              byte_rdy_i
);

    logic             full_q;
    logic             idx_q;
    logic             hi_q;
    logic [BUS_W-1:0] hold_q;
    logic             take;
    logic             consume;
    logic             last_byte;

    // Handshake terms for both sides of the holding register.
    always_comb begin
        take      = port_vld_i && !full_q;
        consume   = full_q && byte_rdy_i;
        last_byte = idx_q || !hi_q;
    end

    // Load a word, then step through its bytes as they are consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            idx_q  <= 1'b0;
            hi_q   <= 1'b0;
            hold_q <= '0;
        end else if (take) begin
            full_q <= 1'b1;
            idx_q  <= 1'b0;
            case (mode_i)
                LINK_WORD: begin
                    hold_q <= port_data_i;
                    hi_q   <= hi_vld_i;
                end
                LINK_BYTE_SPLIT: begin
                    hold_q <= {{LANE_W{1'b0}}, port_data_i[BUS_W-1:LANE_W]};
                    hi_q   <= 1'b0;
                end
                default: begin
                    hold_q <= {{LANE_W{1'b0}}, port_data_i[LANE_W-1:0]};
                    hi_q   <= 1'b0;
                end
            endcase
        end else if (consume) begin
            if (last_byte)
                full_q <= 1'b0;
            else
                idx_q <= 1'b1;
        end
    end

    assign port_rdy_o = !full_q;
    assign byte_vld_o = full_q;
    assign byte_o     = idx_q ? hold_q[BUS_W-1:LANE_W] : hold_q[LANE_W-1:0];

endmodule

// File: rtl/bwa_dir_ctrl.sv
// Direction control: registered output enables per lane and for the
// shared high-half flag. Assumes transmit activity is port_tx_vld.
module bwa_dir_ctrl
    import bwa_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  link_mode_e       mode_i,
    input  logic             tx_on_i,
    output logic [LANES-1:0] lane_oe_o,
    output logic             flag_oe_o
);

    logic flag_oe_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic oe_q;
        // Register this lane's drive enable from layout and tx activity.
        always_ff @(posedge clk) begin
            if (!rst_n)
                oe_q <= 1'b0;
            else
                oe_q <= lane_drives(mode_i, l, tx_on_i);
        end
        assign lane_oe_o[l] = oe_q;
    end

    // Flag points outward only in word layout with transmit idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_oe_q <= 1'b0;
        else
            flag_oe_q <= (mode_i == LINK_WORD) && !tx_on_i;
    end

    assign flag_oe_o = flag_oe_q;

endmodule

// File: rtl/byte_word_adapter.sv
// Top of the byte/word width adapter: layout capture, receive packer,
// transmit unpacker and direction control. Pads are outside this block.
module byte_word_adapter
    import bwa_pkg::*;
#(
    parameter  int LANE_W = 8,
    localparam int LANES  = 2,
    localparam int BUS_W  = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide_i,
    input  logic              cfg_split_i,
    input  logic [LANE_W-1:0] rx_byte_i,
    input  logic              rx_byte_vld_i,
    input  logic              rx_byte_last_i,
    output logic [LANE_W-1:0] tx_byte_o,
    output logic              tx_byte_vld_o,
    input  logic              tx_byte_rdy_i,
    input  logic [BUS_W-1:0]  port_din_i,
    output logic [BUS_W-1:0]  port_dout_o,
    output logic [LANES-1:0]  port_oe_o,
    output logic              port_rx_vld_o,
    input  logic              port_tx_vld_i,
    output logic              port_tx_rdy_o,
    input  logic              port_hbv_i,
    output logic              port_hbv_o,
    output logic              port_hbv_oe_o
);

    link_mode_e mode_w;

    bwa_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide_i  (cfg_wide_i),
        .split_i (cfg_split_i),
        .mode_o  (mode_w)
    );

    bwa_rx_pack #(.LANE_W(LANE_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_w),
        .byte_i      (rx_byte_i),
        .byte_vld_i  (rx_byte_vld_i),
        .byte_last_i (rx_byte_last_i),
        .word_o      (port_dout_o),
        .lo_vld_o    (port_rx_vld_o),
        .hi_vld_o    (port_hbv_o)
    );

    bwa_tx_unpack #(.LANE_W(LANE_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_w),
        .port_vld_i  (port_tx_vld_i),
        .port_data_i (port_din_i),
        .hi_vld_i    (port_hbv_i),
        .port_rdy_o  (port_tx_rdy_o),
        .byte_o      (tx_byte_o),
        .byte_vld_o  (tx_byte_vld_o),
        .byte_rdy_i  (tx_byte_rdy_i)
    );

    bwa_dir_ctrl #(.LANES(LANES)) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_w),
        .tx_on_i   (port_tx_vld_i),
        .lane_oe_o (port_oe_o),
        .flag_oe_o (port_hbv_oe_o)
    );

endmodule

// File: rtl/bwa_chk.sv
// Property checker for the byte/word width adapter, bound to the top.
module bwa_chk
    import bwa_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input link_mode_e        mode,
    input logic              port_tx_vld_i,
    input logic              port_tx_rdy_o,
    input logic [1:0]        port_oe_o,
    input logic              port_rx_vld_o,
    input logic              port_hbv_o,
    input logic              port_hbv_oe_o,
    input logic [LANE_W-1:0] tx_byte_o,
    input logic              tx_byte_vld_o,
    input logic              tx_byte_rdy_i
);

    // R1: layout never moves while out of reset
    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode));

    // R3: byte layouts never raise the high-half flag
    p_no_hi_in_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != LINK_WORD) |-> !port_hbv_o);

    // R4: high half is never flagged without the low half
    p_hi_with_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        port_hbv_o |-> port_rx_vld_o);

    // R6: an offered byte stays put until taken
    p_byte_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_byte_vld_o && !tx_byte_rdy_i) |=> (tx_byte_vld_o && $stable(tx_byte_o)));

    // R7: ready drops right after a word is taken
    p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_tx_vld_i && port_tx_rdy_o) |=> !port_tx_rdy_o);

    // R9: shared lanes turn inward after transmit was active
    p_no_drive_in_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(port_tx_vld_i) && mode != LINK_BYTE_SPLIT) |-> (port_oe_o == 2'b00));

    // R9: split layout never drives the upper lane
    p_split_upper_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LINK_BYTE_SPLIT) |-> !port_oe_o[1]);

    // R10: flag drives outward only in word layout with transmit idle
    p_flag_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && port_hbv_oe_o) |-> (mode == LINK_WORD && !$past(port_tx_vld_i)));

endmodule

bind byte_word_adapter bwa_chk #(.LANE_W(LANE_W)) u_bwa_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode_w),
    .port_tx_vld_i (port_tx_vld_i),
    .port_tx_rdy_o (port_tx_rdy_o),
    .port_oe_o     (port_oe_o),
    .port_rx_vld_o (port_rx_vld_o),
    .port_hbv_o    (port_hbv_o),
    .port_hbv_oe_o (port_hbv_oe_o),
    .tx_byte_o     (tx_byte_o),
    .tx_byte_vld_o (tx_byte_vld_o),
    .tx_byte_rdy_i (tx_byte_rdy_i)
);

// File: tb/test_byte_word_adapter.sv
// Self-checking bench: sweeps packet lengths, words and stall patterns
// in each of the three layouts, with expected values computed here.
module test_byte_word_adapter;

    localparam int LW = 8;
    localparam int BW = 16;
    localparam int MB = 0; // bidirectional byte
    localparam int MS = 1; // split byte
    localparam int MW = 2; // word

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wide, cfg_split;
    logic [LW-1:0] rx_byte;
    logic          rx_vld, rx_last;
    logic [LW-1:0] tx_byte;
    logic          tx_bvld, tx_brdy;
    logic [BW-1:0] din, dout;
    logic [1:0]    oe;
    logic          prx_vld, ptx_vld, ptx_rdy;
    logic          hbv_i, hbv_o, hbv_oe;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    byte_word_adapter #(.LANE_W(LW)) i_byte_word_adapter (
        .clk(clk), .rst_n(rst_n), .cfg_wide_i(cfg_wide), .cfg_split_i(cfg_split),
        .rx_byte_i(rx_byte), .rx_byte_vld_i(rx_vld), .rx_byte_last_i(rx_last),
        .tx_byte_o(tx_byte), .tx_byte_vld_o(tx_bvld), .tx_byte_rdy_i(tx_brdy),
        .port_din_i(din), .port_dout_o(dout), .port_oe_o(oe),
        .port_rx_vld_o(prx_vld), .port_tx_vld_i(ptx_vld), .port_tx_rdy_o(ptx_rdy),
        .port_hbv_i(hbv_i), .port_hbv_o(hbv_o), .port_hbv_oe_o(hbv_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] idle_oe(input int m);
        return (m == MW) ? 2'b11 : 2'b01;
    endfunction

    function automatic logic [1:0] busy_oe(input int m);
        return (m == MS) ? 2'b01 : 2'b00;
    endfunction

    task automatic do_reset(input int m);
        rst_n = 1'b0; rx_vld = 1'b0; rx_last = 1'b0; rx_byte = '0;
        ptx_vld = 1'b0; din = '0; hbv_i = 1'b0; tx_brdy = 1'b1;
        cfg_wide  = (m == MW);
        cfg_split = (m == MS);
        for (int i = 0; i < 3; i++) step();
        check("R2 oe in reset", 32'(oe), 32'h0);
        check("R2 flag oe in reset", 32'(hbv_oe), 32'h0);
        check("R2 rx valid in reset", 32'(prx_vld), 32'h0);
        check("R2 flag in reset", 32'(hbv_o), 32'h0);
        check("R2 tx byte valid in reset", 32'(tx_bvld), 32'h0);
        check("R2 tx ready in reset", 32'(ptx_rdy), 32'h1);
        rst_n = 1'b1;
        cfg_wide  = ~cfg_wide;
        cfg_split = ~cfg_split;
        step();
        check("R1 layout held after release (lane oe)", 32'(oe), 32'(idle_oe(m)));
        check("R1 layout held after release (flag oe)", 32'(hbv_oe), 32'(m == MW));
    endtask

    task automatic rx_packet(input int m, input int len, input bit gap, input int seed);
        logic [7:0] prev;
        prev = '0;
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'(seed + i * 37);
            rx_byte = b; rx_vld = 1'b1; rx_last = (i == len - 1);
            step();
            rx_vld = 1'b0; rx_last = 1'b0;
            if (m != MW) begin
                check("R3 rx valid", 32'(prx_vld), 32'h1);
                check("R3 rx low lane", 32'(dout[7:0]), 32'(b));
                check("R3 flag low", 32'(hbv_o), 32'h0);
            end else if (i % 2 == 1) begin
                check("R4 word valid", 32'(prx_vld), 32'h1);
                check("R4 flag high", 32'(hbv_o), 32'h1);
                check("R4 word data", 32'(dout), 32'({b, prev}));
            end else if (i == len - 1) begin
                check("R5 odd end valid", 32'(prx_vld), 32'h1);
                check("R5 odd end flag", 32'(hbv_o), 32'h0);
                check("R5 odd end data", 32'(dout[7:0]), 32'(b));
            end else begin
                check("R4 no output on first byte", 32'(prx_vld), 32'h0);
            end
            prev = b;
            if (gap) begin
                step();
                check("R4 quiet in gap", 32'(prx_vld), 32'h0);
            end
        end
    endtask

    task automatic send_word(input int m, input logic [15:0] w, input bit hv, input bit stall);
        logic [7:0] exp [2];
        int         nb;
        check("R7 ready before word", 32'(ptx_rdy), 32'h1);
        ptx_vld = 1'b1; din = w; hbv_i = hv;
        step();
        ptx_vld = 1'b0; hbv_i = ~hv; din = ~w;
        check("R7 ready low after take", 32'(ptx_rdy), 32'h0);
        check("R9 lanes during transmit", 32'(oe), 32'(busy_oe(m)));
        check("R10 flag inward during transmit", 32'(hbv_oe), 32'h0);
        if (m == MW) begin
            exp[0] = w[7:0]; exp[1] = w[15:8]; nb = hv ? 2 : 1;
        end else begin
            exp[0] = (m == MS) ? w[15:8] : w[7:0]; exp[1] = '0; nb = 1;
        end
        for (int k = 0; k < nb; k++) begin
            if (stall) begin
                tx_brdy = 1'b0;
                step();
                check("R6 byte held in stall", 32'({tx_bvld, tx_byte}), 32'({1'b1, exp[k]}));
                tx_brdy = 1'b1;
            end
            if (m == MW)
                check("R6 byte order", 32'({tx_bvld, tx_byte}), 32'({1'b1, exp[k]}));
            else
                check("R8 byte lane", 32'({tx_bvld, tx_byte}), 32'({1'b1, exp[k]}));
            check("R7 ready low while bytes left", 32'(ptx_rdy), 32'h0);
            step();
        end
        check("R6 no extra byte", 32'(tx_bvld), 32'h0);
        check("R7 ready after last byte", 32'(ptx_rdy), 32'h1);
        check("R9 lanes back to idle", 32'(oe), 32'(idle_oe(m)));
        check("R10 flag oe back to idle", 32'(hbv_oe), 32'(m == MW));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        for (int m = 0; m < 3; m++) begin
            do_reset(m);
            for (int len = 1; len <= 6; len++) begin
                rx_packet(m, len, 1'b0, len * 11 + m);
                rx_packet(m, len, 1'b1, len * 23 + 5);
            end
            for (int k = 0; k < 8; k++)
                send_word(m, 16'(k * 16'h1357 + 16'h0a5c), k[0], k[1]);
            if (m == MW) begin
                // Receive pair completes on the same edge a transmit word is taken.
                rx_byte = 8'h3c; rx_vld = 1'b1; rx_last = 1'b0;
                step();
                rx_byte = 8'hc3; ptx_vld = 1'b1; din = 16'hbeef; hbv_i = 1'b1;
                step();
                rx_vld = 1'b0; ptx_vld = 1'b0; hbv_i = 1'b0;
                check("R4 word beside transmit", 32'({prx_vld, hbv_o, dout}), 32'({2'b11, 16'hc33c}));
                check("R9 lanes inward beside receive", 32'(oe), 32'h0);
                check("R10 flag inward beside receive", 32'(hbv_oe), 32'h0);
                check("R6 low byte first beside receive", 32'({tx_bvld, tx_byte}), 32'h1ef);
                step();
                check("R6 high byte second", 32'({tx_bvld, tx_byte}), 32'h1be);
                step();
                check("R7 ready after pair", 32'(ptx_rdy), 32'h1);
            end
            if (m == MS) begin
                // Receive byte and transmit word on one edge.
                rx_byte = 8'h5a; rx_vld = 1'b1; rx_last = 1'b1;
                ptx_vld = 1'b1; din = 16'h9671; hbv_i = 1'b1;
                step();
                rx_vld = 1'b0; rx_last = 1'b0; ptx_vld = 1'b0; hbv_i = 1'b0;
                check("R11 receive in parallel", 32'({prx_vld, dout[7:0]}), 32'h15a);
                check("R11 transmit in parallel", 32'({tx_bvld, tx_byte}), 32'h196);
                check("R11 lower lane still out", 32'(oe), 32'h1);
                step();
                check("R11 single byte only", 32'(tx_bvld), 32'h0);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule